// File: doc/BRIEF.md
# Stereo Audio Serial Transmitter

This block sends a two-channel frame of 16-bit audio samples out on one serial data line, most significant bit first. An external clock generator supplies the bit clock and the frame clock. The block samples both clocks in its own system clock domain, finds the falling edges of the bit clock, and counts bit positions within each half of the frame. The frame clock level chooses the half, so it also chooses the output slot.

An upstream source offers one complete frame at a time on a ready/valid port, with sample 0 in the low 16 bits. The frame is taken when the left half starts. A configuration byte sets the following:
- the justification: standard I2S, left-justified or right-justified;
- an independent polarity inversion for each of the two clocks.

A per-slot table chooses which input sample goes to each slot, and a count field turns slots off. When no frame is waiting at a frame start, the block sends silence and sets a sticky underrun flag.

Top module: `stereo_serializer`

## Requirements
- R1: After reset, `sdata`, `underrun` and `in_ready` are all 0.
- R2: With `cfg_fmt[1:0]` = 0 (I2S), each half-frame places its sample MSB first at bit positions 1 to 16, counted from 0 at the first falling bit-clock edge after the frame clock changes. All other positions are 0. `sdata` changes only after a falling edge of the effective bit clock. With normal polarity, the left slot (slot 0) is sent while the frame clock is low.
- R3: With `cfg_fmt[1:0]` = 1 (left-justified), the sample occupies positions 0 to 15.
- R4: With `cfg_fmt[1:0]` = 2 (right-justified), the sample LSB falls on the last position of the half-frame. With 32 bit clocks per half, this is positions 16 to 31.
- R5: When `cfg_fmt[6]` = 1, the bit clock is inverted, so data is launched on rising edges of the raw `bclk_in`.
- R6: When `cfg_fmt[7]` = 1, the frame clock is inverted, so the left slot is sent while the raw `lrck_in` is high. This setting is independent of `cfg_fmt[6]`.
- R7: For slot n, `cfg_chan_map[4n+3:4n]` holds the input sample index. Index k selects `in_data[16k+15:16k]`. An index of 2 or more sends zeros.
- R8: `cfg_chan_sel` holds the number of active slots minus one. A slot n greater than `cfg_chan_sel` sends all zeros.
- R9: `cfg_fmt[1:0]` = 3 is reserved, and in that mode `sdata` stays 0.
- R10: `cfg_fmt[5:2]` (word size and resolution, where 0 means 16-bit) has no effect on the output.
- R11: `in_ready` pulses for one system clock at the first falling bit-clock edge of each left half. A frame is accepted exactly when `in_valid` is high in that cycle.
- R12: If `in_valid` is low at a frame start, both slots of that frame send zeros and `underrun` is set. `underrun` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_in | input | 1 | Bit clock from the clock generator |
| lrck_in | input | 1 | Frame clock from the clock generator |
| cfg_fmt | input | 8 | [1:0] justification, [5:2] word size/resolution, [6] bit clock invert, [7] frame clock invert |
| cfg_chan_sel | input | 3 | Active slot count minus one |
| cfg_chan_map | input | 8 | Input sample index per slot, 4 bits per slot |
| in_valid | input | 1 | Frame offered |
| in_data | input | 32 | Frame: sample 0 in [15:0], sample 1 in [31:16] |
| in_ready | output | 1 | Frame taken this cycle |
| sdata | output | 1 | Serial data out |
| underrun | output | 1 | Sticky: a frame started with no data |

## Verification
Each frame is captured whole, one half at a time, from the serial line at the rising edge of the effective bit clock. The capture is compared against a bit-position image built from the requirements.

The three justification modes use samples whose two ends differ. This makes an off-by-one start position, or a mirrored bit order, visible in the captured image. The polarity runs drive the raw clocks inverted, separately and together. If the design ignored an inversion, the capture would be shifted by one bit or the slots would be swapped.

Further runs use crossed maps, out-of-range indices, a mono count and the reserved mode. These show that routing, slot muting and muting by mode act on each slot independently. A run with a missing frame followed by a good frame separates silence caused by underrun from the sticky flag itself.

// File: rtl/stereo_serializer.sv
module stereo_serializer #(
  parameter int SAMPLE_W  = 16,
  parameter int NUM_CH    = 2,
  parameter int HALF_BITS = 32,
  parameter int MAP_W     = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bclk_in,
  input  logic                       lrck_in,
  input  logic [7:0]                 cfg_fmt,
  input  logic [2:0]                 cfg_chan_sel,
  input  logic [2*MAP_W-1:0]         cfg_chan_map,
  input  logic                       in_valid,
  input  logic [NUM_CH*SAMPLE_W-1:0] in_data,
  output logic                       in_ready,
  output logic                       sdata,
  output logic                       underrun
);
  localparam int CNT_W    = $clog2(HALF_BITS) + 1;
  localparam int RJ_START = HALF_BITS - SAMPLE_W;
  localparam int FRAME_W  = NUM_CH * SAMPLE_W;

  logic [1:0]         bq;
  logic               lr;
  logic               last_lr;
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-1:0] hold;

  logic               bit_fall, half_start, frame_start;
  logic [CNT_W-1:0]   next_pos;
  logic [FRAME_W-1:0] cur_frame;
  logic [MAP_W-1:0]   idx;
  logic [SAMPLE_W-1:0] sample, shifted;
  logic               slot_on, in_win, next_bit;
  int                 pos_i, start_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bq <= 2'b11;
      lr <= 1'b1;
    end else begin
      bq <= {bq[0], bclk_in ^ cfg_fmt[6]};
      lr <= lrck_in ^ cfg_fmt[7];
    end
  end

  assign bit_fall    = bq[1] & ~bq[0];
  assign half_start  = bit_fall & (lr != last_lr);
  assign frame_start = half_start & ~lr;
  assign in_ready    = frame_start;

  assign next_pos  = half_start ? '0 : ((&cnt) ? cnt : cnt + 1'b1);
  assign cur_frame = frame_start ? (in_valid ? in_data : '0) : hold;
  assign idx       = lr ? cfg_chan_map[2*MAP_W-1:MAP_W] : cfg_chan_map[MAP_W-1:0];
  assign slot_on   = (cfg_fmt[1:0] != 2'd3) && ({2'b00, lr} <= cfg_chan_sel);

  always_comb begin
    sample = '0;
    for (int k = 0; k < NUM_CH; k++)
      if (idx == MAP_W'(k)) sample = cur_frame[k*SAMPLE_W +: SAMPLE_W];
  end

  always_comb begin
    pos_i = int'(next_pos);
    case (cfg_fmt[1:0])
      2'd0:    start_i = 1;
      2'd1:    start_i = 0;
      default: start_i = RJ_START;
    endcase
    in_win   = (pos_i >= start_i) && (pos_i < start_i + SAMPLE_W);
    shifted  = in_win ? (sample << (pos_i - start_i)) : '0;
    next_bit = slot_on & in_win & shifted[SAMPLE_W-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_lr  <= 1'b1;
      cnt      <= '0;
      hold     <= '0;
      sdata    <= 1'b0;
      underrun <= 1'b0;
    end else begin
      if (bit_fall) begin
        last_lr <= lr;
        cnt     <= next_pos;
        sdata   <= next_bit;
      end
      if (frame_start) begin
        hold <= cur_frame;
        if (!in_valid) underrun <= 1'b1;
      end
    end
  end
endmodule

module stereo_serializer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_fall,
  input logic       frame_start,
  input logic       in_valid,
  input logic       in_ready,
  input logic       sdata,
  input logic       underrun,
  input logic [1:0] mode
);
  assert_change_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdata) |-> $past(bit_fall));
  assert_reserved_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdata) |-> $past(mode) != 2'd3);
  assert_ready_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !in_ready);
  assert_underrun_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun);
  assert_underrun_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> $past(frame_start && !in_valid));
endmodule

bind stereo_serializer stereo_serializer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_fall(bit_fall), .frame_start(frame_start),
  .in_valid(in_valid), .in_ready(in_ready), .sdata(sdata),
  .underrun(underrun), .mode(cfg_fmt[1:0])
);

// File: tb/stereo_serializer_bench.sv
module stereo_serializer_bench;
  localparam int HALF = 32;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        bclk_in = 1, lrck_in = 1;
  logic [7:0]  cfg_fmt = 8'h00;
  logic [2:0]  cfg_chan_sel = 3'd1;
  logic [7:0]  cfg_chan_map = 8'h10;
  logic        in_valid = 0;
  logic [31:0] in_data = '0;
  logic        in_ready, sdata, underrun;

  int checks = 0, errors = 0, hs_cnt = 0;
  bit done = 0;

  stereo_serializer u_stereo_serializer (
    .clk(clk), .rst_n(rst_n), .bclk_in(bclk_in), .lrck_in(lrck_in),
    .cfg_fmt(cfg_fmt), .cfg_chan_sel(cfg_chan_sel), .cfg_chan_map(cfg_chan_map),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .sdata(sdata), .underrun(underrun)
  );

  always #5 clk = ~clk;

  always @(negedge clk) if (rst_n && in_valid && in_ready) hs_cnt++;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [HALF-1:0] exp_half(input logic [7:0] fmt, input logic [2:0] sel,
      input logic [7:0] map, input int half, input logic [15:0] l, input logic [15:0] r,
      input bit v);
    logic [HALF-1:0] e = '0;
    logic [3:0] id;
    logic [15:0] s;
    int st;
    if (fmt[1:0] == 2'd3 || half > int'(sel)) return e;
    id = half ? map[7:4] : map[3:0];
    s  = !v ? 16'h0 : (id == 4'd0 ? l : (id == 4'd1 ? r : 16'h0));
    st = fmt[1:0] == 2'd0 ? 1 : (fmt[1:0] == 2'd1 ? 0 : HALF - 16);
    for (int i = 0; i < 16; i++) e[st+i] = s[15-i];
    return e;
  endfunction

  task automatic start(input logic [7:0] fmt, input logic [2:0] sel, input logic [7:0] map);
    @(negedge clk);
    cfg_fmt = fmt; cfg_chan_sel = sel; cfg_chan_map = map;
    bclk_in = 1'b1 ^ fmt[6];
    lrck_in = 1'b1 ^ fmt[7];
    in_valid = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    hs_cnt = 0;
  endtask

  task automatic frame(input string req, input logic [15:0] l, input logic [15:0] r, input bit v);
    logic [HALF-1:0] cap;
    in_valid = v;
    in_data  = {r, l};
    for (int h = 0; h < 2; h++) begin
      for (int p = 0; p < HALF; p++) begin
        bclk_in = 1'b0 ^ cfg_fmt[6];
        lrck_in = logic'(h) ^ cfg_fmt[7];
        repeat (4) @(negedge clk);
        cap[p] = sdata;
        bclk_in = 1'b1 ^ cfg_fmt[6];
        repeat (4) @(negedge clk);
      end
      check(req, 64'(cap), 64'(exp_half(cfg_fmt, cfg_chan_sel, cfg_chan_map, h, l, r, v)));
    end
  endtask

  task automatic t_reset;
    start(8'h00, 3'd1, 8'h10);
    check("R1 sdata", 64'(sdata), 64'd0);
    check("R1 underrun", 64'(underrun), 64'd0);
    check("R1 in_ready", 64'(in_ready), 64'd0);
  endtask

  task automatic t_i2s;
    start(8'h00, 3'd1, 8'h10);
    frame("R2 i2s", 16'hA5C3, 16'h3C96, 1);
    frame("R2 i2s", 16'h8001, 16'hFFFE, 1);
    check("R11 handshakes", 64'(hs_cnt), 64'd2);
  endtask

  task automatic t_left;
    start(8'h01, 3'd1, 8'h10);
    frame("R3 left-justified", 16'hC001, 16'h7FF3, 1);
  endtask

  task automatic t_right;
    start(8'h02, 3'd1, 8'h10);
    frame("R4 right-justified", 16'h8003, 16'h1E71, 1);
  endtask

  task automatic t_polarity;
    start(8'h40, 3'd1, 8'h10);
    frame("R5 bclk inverted", 16'h9235, 16'h4C1B, 1);
    start(8'h80, 3'd1, 8'h10);
    frame("R6 lrck inverted", 16'h9235, 16'h4C1B, 1);
    start(8'hC1, 3'd1, 8'h10);
    frame("R5 R6 both inverted", 16'hF00D, 16'h0BAD, 1);
  endtask

  task automatic t_map;
    start(8'h00, 3'd1, 8'h01);
    frame("R7 swapped map", 16'h1234, 16'hABCD, 1);
    start(8'h01, 3'd1, 8'h20);
    frame("R7 out-of-range index", 16'h5A5A, 16'hC3C3, 1);
  endtask

  task automatic t_chan_sel;
    start(8'h00, 3'd0, 8'h10);
    frame("R8 mono count", 16'hBEEF, 16'hCAFE, 1);
  endtask

  task automatic t_reserved;
    start(8'h03, 3'd1, 8'h10);
    frame("R9 reserved mode", 16'hFFFF, 16'hFFFF, 1);
  endtask

  task automatic t_wordsize;
    start(8'h3C, 3'd1, 8'h10);
    frame("R10 word size bits ignored", 16'hA5C3, 16'h3C96, 1);
  endtask

  task automatic t_underrun;
    start(8'h00, 3'd1, 8'h10);
    frame("R12 underrun silence", 16'h7777, 16'h8888, 0);
    check("R12 flag set", 64'(underrun), 64'd1);
    check("R11 no accept without valid", 64'(hs_cnt), 64'd0);
    frame("R12 recovery data", 16'h1357, 16'h2468, 1);
    check("R12 flag sticky", 64'(underrun), 64'd1);
    check("R11 one accept", 64'(hs_cnt), 64'd1);
    start(8'h00, 3'd1, 8'h10);
    check("R12 cleared by reset", 64'(underrun), 64'd0);
  endtask

  initial begin
    t_reset();
    t_i2s();
    t_left();
    t_right();
    t_polarity();
    t_map();
    t_chan_sel();
    t_reserved();
    t_wordsize();
    t_underrun();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule